// File: doc/BRIEF.md
# Elapsed-Millisecond Read Port

This block is a read-only bus target that reports how many whole milliseconds have passed since reset. A prescaler counts clock cycles and, each time it has counted one millisecond's worth, advances a 32-bit millisecond counter. The number of cycles in a millisecond comes from the clock frequency parameter divided by 1000. Address decoding of the one-word window is done upstream, and `sel` is asserted for any access that falls inside it.

Each access is a request held on `sel`, the valid signal, together with `wr`, `addr`, `size` and `bigend`. The block answers with `ready`, and a configured number of wait states holds `ready` low before the access completes. Back-pressure works as follows. While `ready` is low the requester must keep `sel` and the request fields steady and retry on the next cycle. Each cycle with `sel` high and `ready` low counts as one busy response. The access completes in the cycle where `sel` and `ready` are both high. `ready` and `rdata` are combinational in the request, and both read zero while `sel` is low. Reads return a byte, a halfword or the whole word, with the lane chosen in little- or big-endian order. Writes complete the handshake and change nothing.

Top module: `ms_elapsed_port`

## Requirements
- R1: After reset the handshake is idle and the millisecond count is 0, so a read completing in the first cycle after reset returns 0.
- R2: A completed word read returns floor(C / CYCLES_PER_MS), where C is the number of clock edges since reset was released.
- R3: A write (`wr`=1) goes through the same handshake, returns `rdata`=0 and leaves the count unchanged, so a later read still follows R2.
- R4: The effective wait-state count is WAIT_CFG when it lies in 0..30. Any other value is treated as 0.
- R5: With 0 wait states, a request in the idle state has `ready`=1 in the same cycle.
- R6: With N>0 wait states, a request sees exactly N+1 cycles with `sel`=1 and `ready`=0, and completes on the next cycle with `sel`=1.
- R7: Cycles with `sel`=0 during a pending access do not advance the wait countdown, so the busy-cycle count of R6 is unchanged.
- R8: Byte reads (`size`=2'b00) return byte index k = addr XOR (bigend ? 3 : 0) of the count, zero-extended. That byte is bits [8k+7:8k].
- R9: Halfword reads (`size`=2'b01) return bits [8h+15:8h], zero-extended, where h = (addr XOR (bigend ? 3 : 0)) AND 2.
- R10: Word reads (`size`=2'b10 or 2'b11) return the full count whatever `addr` and `bigend` are.
- R11: CYCLES_PER_MS equals CLK_HZ / 1000, so two instances at different clock rates report counts in proportion to those rates.
- R12: While `sel`=0, `ready` and `rdata` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| sel | input | 1 | Request valid (access falls in the decoded window) |
| wr | input | 1 | 1 = write (ignored), 0 = read |
| addr | input | 2 | Byte address within the word |
| size | input | 2 | 00 byte, 01 halfword, 10/11 word |
| bigend | input | 1 | Big-endian lane selection |
| rdata | output | 32 | Read data, zero-extended lane |
| ready | output | 1 | Access completes this cycle |

## Verification
Every combination of byte address, access size and endian mode is swept on a zero-wait instance after the count has grown past 255. The result tells apart lanes holding a nonzero low byte, a nonzero second byte and zero upper bytes, so a swapped lane or a missing XOR shows up. Three instances run side by side: one with three wait states, one with zero, and one with an out-of-range setting. They separate the countdown length from the clamp. A request paused with `sel` low shows whether the countdown stalls. A write followed by a read shows that the count is untouched. The instances use two different clock-rate parameters, which separates the divisor from the counter.

// File: rtl/ms_pkg.sv
package ms_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_WRD2 = 2'b11
  } acc_size_e;

  typedef enum logic {
    HS_IDLE = 1'b0,
    HS_WAIT = 1'b1
  } hs_state_e;

  localparam int MAX_WAITS = 30;
  localparam int WAIT_W    = 5;
endpackage

// File: rtl/ms_prescale_count.sv
module ms_prescale_count #(
  parameter int CYCLES_PER_MS = 100000,
  parameter int CNT_W         = 32
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] ms_count
);
  localparam int PW = (CYCLES_PER_MS > 1) ? $clog2(CYCLES_PER_MS) : 1;
  localparam logic [PW-1:0] LAST = PW'(CYCLES_PER_MS - 1);

  logic [PW-1:0] presc_q;
  logic          wrap;

  assign wrap = (presc_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      presc_q  <= '0;
      ms_count <= '0;
    end else if (wrap) begin
      presc_q  <= '0;
      ms_count <= ms_count + 1'b1;
    end else begin
      presc_q  <= presc_q + 1'b1;
    end
  end
endmodule

// File: rtl/ms_wait_fsm.sv
module ms_wait_fsm
  import ms_pkg::*;
#(
  parameter int WAIT_N = 0
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      sel,
  output logic      go,
  output hs_state_e state,
  output logic [WAIT_W-1:0] wcnt
);
  localparam logic [WAIT_W-1:0] WAIT_L = WAIT_W'(WAIT_N);

  always_comb begin
    case (state)
      HS_IDLE: go = (WAIT_L == '0);
      default: go = (wcnt == '0);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= HS_IDLE;
      wcnt  <= '0;
    end else if (sel) begin
      case (state)
        HS_IDLE: begin
          if (WAIT_L != '0) begin
            state <= HS_WAIT;
            wcnt  <= WAIT_L;
          end
        end
        default: begin
          if (wcnt == '0) state <= HS_IDLE;
          else            wcnt  <= wcnt - 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/ms_lane_pick.sv
module ms_lane_pick
  import ms_pkg::*;
(
  input  logic [31:0] word,
  input  logic [1:0]  addr,
  input  logic [1:0]  size,
  input  logic        bigend,
  output logic [31:0] lane
);
  logic [1:0]  idx;
  logic [31:0] byte_sh;
  logic [31:0] half_sh;

  assign idx     = addr ^ {2{bigend}};
  assign byte_sh = word >> {idx, 3'b000};
  assign half_sh = word >> {idx[1], 4'b0000};

  always_comb begin
    case (acc_size_e'(size))
      SZ_BYTE: lane = {24'd0, byte_sh[7:0]};
      SZ_HALF: lane = {16'd0, half_sh[15:0]};
      default: lane = word;
    endcase
  end
endmodule

// File: rtl/ms_elapsed_port.sv
module ms_elapsed_port
  import ms_pkg::*;
#(
  parameter int CLK_HZ   = 100000000,
  parameter int WAIT_CFG = 0
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        sel,
  input  logic        wr,
  input  logic [1:0]  addr,
  input  logic [1:0]  size,
  input  logic        bigend,
  output logic [31:0] rdata,
  output logic        ready
);
  localparam int CYCLES_PER_MS = CLK_HZ / 1000;
  localparam int WAIT_EFF = (WAIT_CFG < 0 || WAIT_CFG > MAX_WAITS) ? 0 : WAIT_CFG;

  logic [31:0]       ms_val;
  logic [31:0]       lane;
  logic              go;
  hs_state_e         hs_state;
  logic [WAIT_W-1:0] hs_cnt;

  ms_prescale_count #(
    .CYCLES_PER_MS(CYCLES_PER_MS),
    .CNT_W        (32)
  ) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .ms_count(ms_val)
  );

  ms_wait_fsm #(
    .WAIT_N(WAIT_EFF)
  ) u_hs (
    .clk  (clk),
    .rst  (rst),
    .sel  (sel),
    .go   (go),
    .state(hs_state),
    .wcnt (hs_cnt)
  );

  ms_lane_pick u_lane (
    .word  (ms_val),
    .addr  (addr),
    .size  (size),
    .bigend(bigend),
    .lane  (lane)
  );

  assign ready = sel & go;
  assign rdata = (ready && !wr) ? lane : 32'd0;
endmodule

// File: rtl/ms_elapsed_port_chk.sv
module ms_elapsed_port_chk
  import ms_pkg::*;
#(
  parameter int WAIT_EFF = 0
) (
  input logic        clk,
  input logic        rst,
  input logic        sel,
  input logic        wr,
  input logic [1:0]  size,
  input logic [31:0] rdata,
  input logic        ready,
  input logic [31:0] ms_val,
  input hs_state_e   hs_state,
  input logic [WAIT_W-1:0] hs_cnt
);
  // R2
  ms_step_chk: assert property (@(posedge clk) disable iff (rst)
    (ms_val == $past(ms_val)) || (ms_val == $past(ms_val) + 32'd1));

  // R5
  zero_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (WAIT_EFF == 0 && sel) |-> ready);

  // R6
  first_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (WAIT_EFF != 0 && sel && hs_state == HS_IDLE) |-> !ready);

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !sel |=> ($stable(hs_state) && $stable(hs_cnt)));

  // R3
  write_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (sel && wr) |-> (rdata == 32'd0));

  // R8
  byte_ext_chk: assert property (@(posedge clk) disable iff (rst)
    (sel && ready && size == SZ_BYTE) |-> (rdata[31:8] == 24'd0));

  // R12
  idle_out_chk: assert property (@(posedge clk) disable iff (rst)
    !sel |-> (!ready && rdata == 32'd0));
endmodule

bind ms_elapsed_port ms_elapsed_port_chk #(.WAIT_EFF(WAIT_EFF)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .sel     (sel),
  .wr      (wr),
  .size    (size),
  .rdata   (rdata),
  .ready   (ready),
  .ms_val  (ms_val),
  .hs_state(hs_state),
  .hs_cnt  (hs_cnt)
);

// File: tb/ms_elapsed_port_tb_top.sv
module ms_elapsed_port_tb_top;
  localparam int PERIOD = 10;
  localparam int CPM_A  = 3;   // dut0 and dut_bad: CLK_HZ 3000
  localparam int CPM_B  = 4;   // dut_i: CLK_HZ 4000
  localparam int WAITS_B = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [1:0] size = 2'd2;
  logic bigend = 1'b0;
  logic [2:0] sel = 3'b000;
  logic [31:0] rd [3];
  logic [2:0]  rdy;
  int cyc = 0;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= rst ? 0 : cyc + 1;

  ms_elapsed_port #(.CLK_HZ(4000), .WAIT_CFG(WAITS_B)) dut_i (
    .clk(clk), .rst(rst), .sel(sel[0]), .wr(wr), .addr(addr), .size(size),
    .bigend(bigend), .rdata(rd[0]), .ready(rdy[0]));
  ms_elapsed_port #(.CLK_HZ(3000), .WAIT_CFG(0)) dut0 (
    .clk(clk), .rst(rst), .sel(sel[1]), .wr(wr), .addr(addr), .size(size),
    .bigend(bigend), .rdata(rd[1]), .ready(rdy[1]));
  ms_elapsed_port #(.CLK_HZ(3000), .WAIT_CFG(40)) dut_bad (
    .clk(clk), .rst(rst), .sel(sel[2]), .wr(wr), .addr(addr), .size(size),
    .bigend(bigend), .rdata(rd[2]), .ready(rdy[2]));

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint lane_exp(longint v, int a, int sz, bit be);
    int b;
    int h;
    b = be ? (a ^ 3) : a;
    h = b & 2;
    if (sz == 0) return (v >> (8*b)) % 256;
    if (sz == 1) return (v >> (8*h)) % 65536;
    return v;
  endfunction

  // one access: held until ready, with optional pause of sel low
  task automatic access(int which, bit w, int a, int sz, bit be, int pause_at,
                        output int busy, output longint data, output int at);
    busy = 0;
    wr = w; addr = 2'(a); size = 2'(sz); bigend = be;
    sel[which] = 1'b1;
    forever begin
      #1;
      if (rdy[which]) begin
        data = rd[which];
        at = cyc;
        break;
      end
      busy++;
      if (busy == pause_at) begin
        @(negedge clk);
        sel[which] = 1'b0;
        repeat (5) @(negedge clk);
        sel[which] = 1'b1;
      end else begin
        @(negedge clk);
      end
    end
    @(negedge clk);
    sel[which] = 1'b0;
    wr = 1'b0;
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int busy;
    int at;
    longint d;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 R5: first read right after reset, zero waits
    access(1, 1'b0, 0, 2, 1'b0, -1, busy, d, at);
    check("R1 first read value", d, at / CPM_A);
    check("R5 zero-wait busy", busy, 0);
    // R1 R6: idle after reset on waited instance
    access(0, 1'b0, 0, 2, 1'b0, -1, busy, d, at);
    check("R1 R6 busy after reset", busy, WAITS_B + 1);

    // R12: outputs quiet with sel low
    #1;
    check("R12 ready idle", rdy, 0);
    check("R12 rdata idle", rd[1], 0);

    repeat (2000) @(negedge clk);

    // R8 R9 R10 R2: full lane sweep on zero-wait instance
    for (int be = 0; be < 2; be++)
      for (int sz = 0; sz < 4; sz++)
        for (int a = 0; a < 4; a++) begin
          access(1, 1'b0, a, sz, be[0], -1, busy, d, at);
          check(sz == 0 ? "R8 byte lane" : (sz == 1 ? "R9 half lane" : "R10 word"),
                d, lane_exp(at / CPM_A, a, sz, be[0]));
          check("R5 sweep busy", busy, 0);
        end

    // R4: out-of-range wait setting behaves as zero
    access(2, 1'b0, 0, 2, 1'b0, -1, busy, d, at);
    check("R4 clamp busy", busy, 0);
    check("R4 clamp value", d, at / CPM_A);

    // R6 R11: waited instance, different clock rate
    for (int k = 0; k < 3; k++) begin
      access(0, 1'b0, 0, 2, 1'b0, -1, busy, d, at);
      check("R6 busy count", busy, WAITS_B + 1);
      check("R11 rate scaled value", d, at / CPM_B);
      repeat (37) @(negedge clk);
    end

    // R7: pause with sel low in the middle of the countdown
    access(0, 1'b0, 1, 0, 1'b1, 2, busy, d, at);
    check("R7 paused busy count", busy, WAITS_B + 1);
    check("R7 paused value", d, lane_exp(at / CPM_B, 1, 0, 1'b1));

    // R3: writes complete, return zero, count untouched
    access(1, 1'b1, 0, 2, 1'b0, -1, busy, d, at);
    check("R3 write busy", busy, 0);
    check("R3 write rdata", d, 0);
    access(0, 1'b1, 2, 1, 1'b0, -1, busy, d, at);
    check("R3 write handshake", busy, WAITS_B + 1);
    check("R3 write rdata waited", d, 0);
    repeat (10) @(negedge clk);
    access(1, 1'b0, 0, 2, 1'b0, -1, busy, d, at);
    check("R3 count after write", d, at / CPM_A);
    access(0, 1'b0, 0, 2, 1'b0, -1, busy, d, at);
    check("R3 count after write waited", d, at / CPM_B);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule